// File: doc/BRIEF.md
# Plug-and-play resource data reader

This block sits between a host register port and a serial configuration EEPROM with a four-wire interface (select, serial clock, data to the device, data from the device). It fetches one byte at a time from the EEPROM and stores it in a resource data register. A ready flag in a status register tells the host when the byte can be taken. The first nine bytes of the serial stream are the card identifier, and the resource data follows them. The block tracks a simple card state of sleep, isolation or configuration. It serves bytes only in configuration, and it moves its byte pointer when the card is woken or gets its card select number (CSN).

The host polls the status register until the ready bit is set, then reads the data register. That read clears the flag and starts the shift of the next byte. A card that reaches configuration by being assigned a CSN out of isolation starts at the first resource byte. A card that is woken out of sleep starts again at byte 0, so the host must read the identifier bytes first.

Top module: `pnp_res_reader`

## Requirements
- R1: After a synchronous reset the card is in sleep, the pointer is 0, the ready flag is clear, both host registers read 0x00 and the EEPROM select is low.
- R2: Outside the configuration state, both host registers read 0x00, data register reads have no effect and no serial access starts.
- R3: `cmd_op`=1 (assign) in isolation stores `cmd_csn` and enters configuration with the pointer at byte 9, so the first data read returns the first resource byte. `cmd_op`=0 (isolate) moves the card from sleep to isolation and is ignored in other states.
- R4: `cmd_op`=2 (wake) always rewinds the pointer to byte 0. If `cmd_csn` equals a nonzero stored CSN the card enters configuration, and the host then reads identifier bytes 0 to 8 before resource byte 9.
- R5: A wake whose argument does not match the stored CSN, and `cmd_op`=3 (sleep), put the card in sleep. Every command aborts any serial burst in progress and clears the ready flag.
- R6: Status register (`rd_sel`=0) reads {7'b0, ready}. Ready is set once eight bits have been collected into the data register.
- R7: A data register read (`rd_sel`=1) while ready is set clears ready at once and starts the shift of the next stream byte. Bytes come out in address order.
- R8: A data register read while ready is clear returns the previous contents and neither moves the pointer nor skips a byte.
- R9: Each burst sends the bits 1,1,0 followed by the address MSB first, then shifts data in MSB first. `ee_sk` toggles every `DIV` clocks. The device samples on the rising edge and changes data after the falling edge. One command is sent per sequential burst.
- R10: After the last EEPROM byte has been taken, the data register holds 0xFF and ready stays set for all later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Card command strobe |
| cmd_op | input | 2 | 0 isolate, 1 assign CSN, 2 wake, 3 sleep |
| cmd_csn | input | CSN_W | CSN argument of assign or wake |
| rd_stb | input | 1 | Host register read strobe |
| rd_sel | input | 1 | 0 status, 1 resource data |
| rd_data | output | 8 | Selected register value |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to EEPROM |
| ee_do | input | 1 | Serial data from EEPROM |

## Verification
The assertions check on every cycle that:
- ready is never set outside configuration;
- the serial clock is idle whenever select is low, and select is low outside configuration;
- a ready data read clears the flag, or loads 0xFF at the last address;
- a read while not ready leaves the pointer alone;
- a wake rewinds the pointer.

Only the bench's scenarios, run against a behavioural EEPROM, can show:
- the command header is correct;
- bytes arrive in order with the right values;
- the two entry paths start at byte 9 and byte 0;
- a wake in the middle of a burst restarts the stream;
- the saturation values at the end of the device.

// File: rtl/pnp_res_reader.sv
module pnp_res_reader #(
  parameter int DEPTH  = 128,
  parameter int DIV    = 2,
  parameter int ID_LEN = 9,
  parameter int CSN_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [CSN_W-1:0] cmd_csn,
  input  logic             rd_stb,
  input  logic             rd_sel,
  output logic [7:0]       rd_data,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  input  logic             ee_do
);
  localparam int AW      = $clog2(DEPTH);
  localparam int CMD_LEN = 3 + AW;
  localparam int BMAX    = (CMD_LEN > 8) ? CMD_LEN : 8;
  localparam int BW      = $clog2(BMAX + 1);
  localparam int CW      = $clog2(DIV + 1);
  localparam int LAST    = DEPTH - 1;

  typedef enum logic [1:0] {C_SLEEP, C_ISO, C_CFG} card_t;
  typedef enum logic [1:0] {E_IDLE, E_CMD, E_DATA, E_HOLD} eng_t;

  card_t              cst;
  eng_t               eng;
  logic [AW-1:0]      ptr;
  logic [CSN_W-1:0]   csn;
  logic               ready;
  logic [7:0]         data_q, shreg;
  logic [CMD_LEN-1:0] cmd_sr;
  logic [BW-1:0]      bitcnt;
  logic [CW-1:0]      cnt;

  wire in_cfg  = (cst == C_CFG);
  wire tick    = (cnt == CW'(DIV - 1));
  wire take    = rd_stb && rd_sel && !cmd_valid && in_cfg && ready;
  wire at_last = (ptr == AW'(LAST));

  assign rd_data = !in_cfg ? 8'h00 : (rd_sel ? data_q : {7'b0, ready});
  assign ee_di   = ee_cs && (eng == E_CMD) && cmd_sr[CMD_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cst <= C_SLEEP; eng <= E_IDLE; ptr <= '0; csn <= '0; ready <= 1'b0;
      data_q <= '0; shreg <= '0; cmd_sr <= '0; bitcnt <= '0; cnt <= '0;
      ee_cs <= 1'b0; ee_sk <= 1'b0;
    end else if (cmd_valid) begin
      eng <= E_IDLE; ee_cs <= 1'b0; ee_sk <= 1'b0; ready <= 1'b0;
      case (cmd_op)
        2'd0: if (cst == C_SLEEP) cst <= C_ISO;
        2'd1: if (cst == C_ISO) begin
                cst <= C_CFG; csn <= cmd_csn; ptr <= AW'(ID_LEN);
              end
        2'd2: begin
                ptr <= '0;
                cst <= (cmd_csn == csn && csn != '0) ? C_CFG : C_SLEEP;
              end
        default: cst <= C_SLEEP;
      endcase
    end else if (take) begin
      if (at_last) begin
        data_q <= 8'hFF; eng <= E_IDLE; ee_cs <= 1'b0;
      end else begin
        ptr <= ptr + 1'b1; ready <= 1'b0; eng <= E_DATA;
        bitcnt <= '0; cnt <= '0;
      end
    end else begin
      case (eng)
        E_IDLE: if (in_cfg && !ready) begin
          eng <= E_CMD; ee_cs <= 1'b1; cmd_sr <= {3'b110, ptr};
          bitcnt <= '0; cnt <= '0;
        end
        E_CMD, E_DATA: if (tick) begin
          cnt   <= '0;
          ee_sk <= !ee_sk;
          if (!ee_sk) begin
            bitcnt <= bitcnt + 1'b1;
            if (eng == E_DATA) shreg <= {shreg[6:0], ee_do};
          end else if (eng == E_CMD) begin
            cmd_sr <= cmd_sr << 1;
            if (bitcnt == BW'(CMD_LEN)) begin
              eng <= E_DATA; bitcnt <= '0;
            end
          end else if (bitcnt == BW'(8)) begin
            data_q <= shreg; ready <= 1'b1; eng <= E_HOLD;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

module pnp_res_reader_chk #(
  parameter int AW   = 7,
  parameter int LAST = 127
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic          rd_stb,
  input logic          rd_sel,
  input logic          in_cfg,
  input logic          ready,
  input logic [AW-1:0] ptr,
  input logic [7:0]    data_q,
  input logic          ee_cs,
  input logic          ee_sk
);
  a_r2_ready_only_in_cfg: assert property (@(posedge clk) disable iff (rst)
    ready |-> in_cfg);
  a_r2_no_serial_outside_cfg: assert property (@(posedge clk) disable iff (rst)
    !in_cfg |-> !ee_cs);
  a_r9_sk_idle_when_deselected: assert property (@(posedge clk) disable iff (rst)
    !ee_cs |-> !ee_sk);
  a_r7_take_clears_ready: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_sel && in_cfg && ready && !cmd_valid && ptr != AW'(LAST)) |=> !ready);
  a_r8_idle_read_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_sel && !ready && !cmd_valid) |=> $stable(ptr));
  a_r4_wake_rewinds: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd2) |=> (ptr == '0 && !ready));
  a_r10_saturate_ff: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_sel && in_cfg && ready && !cmd_valid && ptr == AW'(LAST))
      |=> (ready && data_q == 8'hFF));
endmodule

bind pnp_res_reader pnp_res_reader_chk #(.AW(AW), .LAST(LAST)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rd_stb(rd_stb), .rd_sel(rd_sel), .in_cfg(in_cfg), .ready(ready),
  .ptr(ptr), .data_q(data_q), .ee_cs(ee_cs), .ee_sk(ee_sk)
);

// File: tb/pnp_res_reader_bench.sv
module pnp_res_reader_bench;
  localparam int DEPTH = 128;
  localparam int AW    = 7;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [7:0] cmd_csn = 0;
  logic rd_stb = 0, rd_sel = 0;
  logic [7:0] rd_data;
  logic ee_cs, ee_sk, ee_di;
  logic ee_do = 0;

  int total = 0, failed = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pnp_res_reader u_pnp_res_reader (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_csn(cmd_csn), .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  function automatic logic [7:0] romb(int i);
    return 8'((i * 73 + 29) ^ (i >> 2));
  endfunction

  function automatic logic [7:0] expb(int i);
    return (i < DEPTH) ? romb(i) : 8'hFF;
  endfunction

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // behavioural serial EEPROM, observed away from the active edge
  logic psk = 0, mdata = 0;
  logic [2:0] hdr = 0;
  logic [AW-1:0] maddr = 0;
  int mcnt = 0, mbit = 0, hdr_err = 0;
  always @(negedge clk) begin
    if (!ee_cs) begin
      mcnt = 0; mdata = 0; mbit = 0; maddr = 0; psk = 0; hdr = 0;
    end else begin
      if (ee_sk && !psk && !mdata) begin
        if (mcnt < 3) hdr = {hdr[1:0], ee_di};
        else maddr = {maddr[AW-2:0], ee_di};
        mcnt++;
        if (mcnt == 3 + AW) begin
          mdata = 1;
          if (hdr != 3'b110) hdr_err++;
        end
      end else if (!ee_sk && psk && mdata) begin
        logic [7:0] b;
        b = romb(int'(maddr));
        ee_do = b[7 - mbit];
        mbit++;
        if (mbit == 8) begin mbit = 0; maddr = maddr + 1'b1; end
      end
      psk = ee_sk;
    end
  end

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk); rd_sel = sel; rd_stb = 1; #1 v = rd_data;
    @(posedge clk); #1 rd_stb = 0;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [7:0] c);
    @(negedge clk); cmd_op = op; cmd_csn = c; cmd_valid = 1;
    @(posedge clk); #1 cmd_valid = 0;
  endtask

  task automatic get_byte(input string req, input logic [7:0] exp);
    logic [7:0] s, v;
    s = 0;
    for (int k = 0; k < 3000 && s[0] == 1'b0; k++) rd(0, s);
    chk(s == 8'h01, "R6 status ready", s, 8'h01);
    rd(1, v);
    chk(v == exp, req, v, exp);
  endtask

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    rd(0, v); chk(v == 8'h00, "R1 status after reset", v, 8'h00);
    rd(1, v); chk(v == 8'h00, "R1 data after reset", v, 8'h00);
    chk(ee_cs == 0, "R1 select low", {7'b0, ee_cs}, 8'h00);
    // R2 sleep reads
    repeat (40) @(negedge clk);
    rd(1, v); chk(v == 8'h00, "R2 data in sleep", v, 8'h00);
    chk(ee_cs == 0, "R2 no serial access", {7'b0, ee_cs}, 8'h00);
    // R3 isolation then assign
    cmd(2'd0, 8'd0);
    rd(1, v); chk(v == 8'h00, "R2 data in isolation", v, 8'h00);
    cmd(2'd1, 8'd5);
    get_byte("R3 first resource byte", romb(9));
    rd(0, v); chk(v == 8'h00, "R7 ready cleared by read", v, 8'h00);
    rd(1, v); chk(v == romb(9), "R8 stale read returns previous", v, romb(9));
    get_byte("R8 no skipped byte", romb(10));
    get_byte("R7 sequential", romb(11));
    // R4 sleep then wake
    cmd(2'd3, 8'd0);
    rd(1, v); chk(v == 8'h00, "R5 sleep blocks reads", v, 8'h00);
    cmd(2'd2, 8'd5);
    for (int i = 0; i < 10; i++) get_byte("R4 identifier then resource", romb(i));
    // R4 wake in the middle of a burst
    cmd(2'd2, 8'd5);
    get_byte("R4 rewind mid burst", romb(0));
    repeat (5) @(negedge clk);
    cmd(2'd2, 8'd5);
    get_byte("R4 rewind again", romb(0));
    // R5 mismatching wake
    cmd(2'd2, 8'd7);
    rd(0, v); chk(v == 8'h00, "R5 mismatch wake sleeps", v, 8'h00);
    rd(1, v); chk(v == 8'h00, "R5 mismatch data", v, 8'h00);
    cmd(2'd2, 8'd0);
    rd(0, v); chk(v == 8'h00, "R5 wake zero sleeps", v, 8'h00);
    cmd(2'd1, 8'd9);
    rd(0, v); chk(v == 8'h00, "R3 assign ignored in sleep", v, 8'h00);
    // random bursts
    for (int it = 0; it < 20; it++) begin
      cmd(2'd2, 8'd5);
      n = $urandom_range(1, 15);
      for (int i = 0; i < n; i++) begin
        get_byte("R7 random stream", romb(i));
        if ($urandom_range(0, 3) == 0) begin
          rd(1, v); chk(v == romb(i), "R8 random stale read", v, romb(i));
        end
      end
    end
    // R10 saturation
    cmd(2'd2, 8'd5);
    for (int i = 0; i < DEPTH + 3; i++) get_byte("R10 stream to end", expb(i));
    rd(0, v); chk(v == 8'h01, "R10 ready stays set", v, 8'h01);
    chk(ee_cs == 0, "R10 select released", {7'b0, ee_cs}, 8'h00);
    // R9 command header
    chk(hdr_err == 0, "R9 command header", 8'(hdr_err), 8'h00);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule